// File: doc/BRIEF.md
# Critical-Word-First Block Fill Sequencer

This block loads one cache block from a main store that is split across several interleaved memory modules, each one word wide. With the default parameters, a block is 64 bytes and holds four 16-byte words. Module k holds word k of every block, which is bytes 16k to 16k+15. The cache controller sends a fill request that carries the block address and the index of the word the processor is waiting for. The sequencer then makes exactly one access to each module. It starts with the module that holds the wanted word and continues through the others in rising index order, wrapping from the last module back to module 0.

Each word that comes back is written into the cache data array one cycle after the module strobes it valid. The first word is the one the processor asked for, and it is presented to the processor on the same cycle and with the same data as its write into the array. After the last word has been written, a single-cycle completion pulse tells the directory it may mark the block valid. The block accepts no new request until that pulse has been given.

Each module uses a simple request/valid handshake. A module request stays raised until that module returns valid data, however many wait cycles it takes.

Top module: `cwf_fill_seq`

## Requirements
- R1: While reset is held and while idle, busy_o is 0, req_ready_o is 1, and mod_req_o, ram_we_o, cpu_valid_o and done_o are all 0.
- R2: Each fill makes exactly one completed handshake with each module, and at most one bit of mod_req_o is high at any time.
- R3: The first data-array write of a fill has ram_idx_o equal to the requested word index req_word_i.
- R4: After the first write, each following write has ram_idx_o one greater than the previous write's, wrapping from N_MOD-1 to 0.
- R5: cpu_valid_o is high exactly once per fill, on the cycle of the first write, and cpu_data_o then equals ram_wdata_o.
- R6: While a module request is raised, mod_addr_o equals the block address of the fill. Each write's ram_wdata_o is the data the module with number ram_idx_o returned, and ram_blk_o is the fill's block address.
- R7: done_o is a one-cycle pulse on the cycle right after the N_MOD-th write of the fill, with done_blk_o equal to the fill's block address. No write occurs on the cycle of the pulse.
- R8: From the accepting edge through the done pulse, req_ready_o is 0 and busy_o is 1. Requests presented in that period are ignored: the fill's address and order do not change, and the block is idle on the cycle after done.
- R9: A raised module request bit stays unchanged until that module returns valid data, for any number of wait cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Fill request strobe |
| req_ready_o | output | 1 | Request is accepted when this and req_valid_i are both high |
| req_blk_i | input | BLK_W | Block address to fill |
| req_word_i | input | IDX_W | Index of the word the processor wants |
| busy_o | output | 1 | A fill is in progress |
| mod_req_o | output | N_MOD | One request line per memory module |
| mod_addr_o | output | BLK_W | Block address presented to the modules |
| mod_valid_i | input | N_MOD | Per-module return-data strobe |
| mod_rdata_i | input | N_MOD*WORD_W | Return data; module k occupies bits k*WORD_W upward |
| ram_we_o | output | 1 | Data-array write enable |
| ram_blk_o | output | BLK_W | Data-array block address |
| ram_idx_o | output | IDX_W | Word index within the block |
| ram_wdata_o | output | WORD_W | Data-array write data |
| cpu_valid_o | output | 1 | Requested word is forwarded to the processor |
| cpu_data_o | output | WORD_W | Forwarded word |
| done_o | output | 1 | Fill-complete pulse |
| done_blk_o | output | BLK_W | Block address of the completed fill |

## Verification
The properties assume that a module raises its valid strobe only while its own request line is high, and for a single cycle per access. They also assume that the strobe falls again once the sequencer has taken the data. The bench's memory model follows these rules. It answers only the module whose request is raised, after a random count of zero or more wait cycles. It holds valid for one cycle and then clears it on the next clock edge. Stray requests during a fill are raised only while req_ready_o is low, so they test the ignore rule without breaking the handshake the model assumes.

// File: rtl/cwf_fill_pkg.sv
package cwf_fill_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_WRITE = 2'd2,
    ST_DONE  = 2'd3
  } fill_st_e;
endpackage

// File: rtl/cwf_order_gen.sv
module cwf_order_gen #(
  parameter int N_MOD = 4,
  parameter int IDX_W = 2
) (
  input  logic [IDX_W-1:0] start_i,
  input  logic [IDX_W-1:0] step_i,
  output logic [IDX_W-1:0] idx_o
);
  localparam bit POW2 = ((1 << IDX_W) == N_MOD);

  generate
    if (POW2) begin : g_pow2
      // natural wrap of the index width
      assign idx_o = start_i + step_i;
    end else begin : g_mod
      logic [IDX_W:0] sum;
      assign sum   = {1'b0, start_i} + {1'b0, step_i};
      assign idx_o = (sum >= (IDX_W+1)'(N_MOD)) ? IDX_W'(sum - (IDX_W+1)'(N_MOD))
                                                : IDX_W'(sum);
    end
  endgenerate
endmodule

// File: rtl/cwf_resp_mux.sv
module cwf_resp_mux #(
  parameter int N_MOD  = 4,
  parameter int WORD_W = 128,
  parameter int IDX_W  = 2
) (
  input  logic [N_MOD-1:0]        valid_i,
  input  logic [N_MOD*WORD_W-1:0] data_i,
  input  logic [IDX_W-1:0]        sel_i,
  output logic                    sel_valid_o,
  output logic [WORD_W-1:0]       sel_data_o
);
  logic [WORD_W-1:0] words [N_MOD];

  for (genvar g = 0; g < N_MOD; g++) begin : g_slice
    assign words[g] = data_i[g*WORD_W +: WORD_W];
  end

  always_comb begin
    sel_valid_o = 1'b0;
    sel_data_o  = '0;
    for (int k = 0; k < N_MOD; k++) begin
      if (sel_i == IDX_W'(k)) begin
        sel_valid_o = valid_i[k];
        sel_data_o  = words[k];
      end
    end
  end
endmodule

// File: rtl/cwf_fill_fsm.sv
module cwf_fill_fsm
  import cwf_fill_pkg::*;
#(
  parameter int N_MOD = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_fire_i,
  input  logic             sel_valid_i,
  output fill_st_e         st_o,
  output logic [IDX_W-1:0] step_o
);
  localparam logic [IDX_W-1:0] LAST_STEP = IDX_W'(N_MOD - 1);

  fill_st_e         st_q, st_d;
  logic [IDX_W-1:0] step_q, step_d;

  always_comb begin
    st_d   = st_q;
    step_d = step_q;
    unique case (st_q)
      ST_IDLE: begin
        if (req_fire_i) begin
          st_d   = ST_FETCH;
          step_d = '0;
        end
      end
      ST_FETCH: begin
        if (sel_valid_i) st_d = ST_WRITE;
      end
      ST_WRITE: begin
        if (step_q == LAST_STEP) begin
          st_d = ST_DONE;
        end else begin
          st_d   = ST_FETCH;
          step_d = step_q + 1'b1;
        end
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      step_q <= '0;
    end else begin
      st_q   <= st_d;
      step_q <= step_d;
    end
  end

  assign st_o   = st_q;
  assign step_o = step_q;
endmodule

// File: rtl/cwf_fill_seq.sv
module cwf_fill_seq
  import cwf_fill_pkg::*;
#(
  parameter int N_MOD  = 4,
  parameter int WORD_W = 128,
  parameter int BLK_W  = 20,
  localparam int IDX_W = (N_MOD > 1) ? $clog2(N_MOD) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_valid_i,
  output logic                    req_ready_o,
  input  logic [BLK_W-1:0]        req_blk_i,
  input  logic [IDX_W-1:0]        req_word_i,
  output logic                    busy_o,
  output logic [N_MOD-1:0]        mod_req_o,
  output logic [BLK_W-1:0]        mod_addr_o,
  input  logic [N_MOD-1:0]        mod_valid_i,
  input  logic [N_MOD*WORD_W-1:0] mod_rdata_i,
  output logic                    ram_we_o,
  output logic [BLK_W-1:0]        ram_blk_o,
  output logic [IDX_W-1:0]        ram_idx_o,
  output logic [WORD_W-1:0]       ram_wdata_o,
  output logic                    cpu_valid_o,
  output logic [WORD_W-1:0]       cpu_data_o,
  output logic                    done_o,
  output logic [BLK_W-1:0]        done_blk_o
);
  fill_st_e          st;
  logic [IDX_W-1:0]  step;
  logic [IDX_W-1:0]  cur_idx;
  logic              sel_valid;
  logic [WORD_W-1:0] sel_data;
  logic              req_fire;
  logic              take;

  logic [BLK_W-1:0]  blk_q;
  logic [IDX_W-1:0]  start_q;
  logic [IDX_W-1:0]  widx_q;
  logic [WORD_W-1:0] wdata_q;

  assign req_ready_o = (st == ST_IDLE);
  assign req_fire    = req_valid_i & req_ready_o;
  assign take        = (st == ST_FETCH) & sel_valid;

  cwf_fill_fsm #(.N_MOD(N_MOD), .IDX_W(IDX_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_fire_i  (req_fire),
    .sel_valid_i (take),
    .st_o        (st),
    .step_o      (step)
  );

  cwf_order_gen #(.N_MOD(N_MOD), .IDX_W(IDX_W)) u_order (
    .start_i (start_q),
    .step_i  (step),
    .idx_o   (cur_idx)
  );

  cwf_resp_mux #(.N_MOD(N_MOD), .WORD_W(WORD_W), .IDX_W(IDX_W)) u_mux (
    .valid_i     (mod_valid_i),
    .data_i      (mod_rdata_i),
    .sel_i       (cur_idx),
    .sel_valid_o (sel_valid),
    .sel_data_o  (sel_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blk_q   <= '0;
      start_q <= '0;
    end else if (req_fire) begin
      blk_q   <= req_blk_i;
      start_q <= req_word_i;
    end
  end

  // registered return word: one write cycle per handshake
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      widx_q  <= '0;
      wdata_q <= '0;
    end else if (take) begin
      widx_q  <= cur_idx;
      wdata_q <= sel_data;
    end
  end

  for (genvar g = 0; g < N_MOD; g++) begin : g_req
    assign mod_req_o[g] = (st == ST_FETCH) && (cur_idx == IDX_W'(g));
  end

  assign busy_o      = (st != ST_IDLE);
  assign mod_addr_o  = blk_q;
  assign ram_we_o    = (st == ST_WRITE);
  assign ram_blk_o   = blk_q;
  assign ram_idx_o   = widx_q;
  assign ram_wdata_o = wdata_q;
  assign cpu_valid_o = (st == ST_WRITE) && (step == '0);
  assign cpu_data_o  = wdata_q;
  assign done_o      = (st == ST_DONE);
  assign done_blk_o  = blk_q;
endmodule

// File: rtl/cwf_fill_seq_chk.sv
module cwf_fill_seq_chk #(
  parameter int N_MOD  = 4,
  parameter int WORD_W = 128,
  parameter int BLK_W  = 20,
  parameter int IDX_W  = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [IDX_W-1:0]  req_word_i,
  input logic              busy_o,
  input logic [N_MOD-1:0]  mod_req_o,
  input logic [BLK_W-1:0]  mod_addr_o,
  input logic [N_MOD-1:0]  mod_valid_i,
  input logic              ram_we_o,
  input logic [IDX_W-1:0]  ram_idx_o,
  input logic [WORD_W-1:0] ram_wdata_o,
  input logic              cpu_valid_o,
  input logic [WORD_W-1:0] cpu_data_o,
  input logic              done_o
);
  localparam int CNT_W = $clog2(N_MOD + 1);

  logic [IDX_W-1:0] word_q;
  logic [IDX_W-1:0] prev_idx_q;
  logic [IDX_W-1:0] next_idx;
  logic [CNT_W-1:0] wr_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q     <= '0;
      prev_idx_q <= '0;
      wr_cnt_q   <= '0;
    end else begin
      if (req_valid_i && req_ready_o) begin
        word_q   <= req_word_i;
        wr_cnt_q <= '0;
      end else if (ram_we_o) begin
        wr_cnt_q <= wr_cnt_q + 1'b1;
      end
      if (ram_we_o) prev_idx_q <= ram_idx_o;
    end
  end

  assign next_idx = (prev_idx_q == IDX_W'(N_MOD - 1)) ? '0 : prev_idx_q + 1'b1;

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (mod_req_o == '0) && !ram_we_o && !done_o);

  p_one_module_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(mod_req_o));

  p_first_word_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_valid_o |-> ram_idx_o == word_q);

  p_wrap_order_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_we_o && !cpu_valid_o) |-> ram_idx_o == next_idx);

  p_forward_with_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_valid_o |-> ram_we_o && (cpu_data_o == ram_wdata_o));

  p_done_after_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(ram_we_o) && !ram_we_o && (wr_cnt_q == CNT_W'(N_MOD)));

  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_addr_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !req_ready_o && $past(busy_o)) |-> $stable(mod_addr_o));

  p_req_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mod_req_o != '0) && ((mod_req_o & mod_valid_i) == '0)) |=> $stable(mod_req_o));
endmodule

bind cwf_fill_seq cwf_fill_seq_chk #(
  .N_MOD(N_MOD), .WORD_W(WORD_W), .BLK_W(BLK_W), .IDX_W(IDX_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .req_word_i  (req_word_i),
  .busy_o      (busy_o),
  .mod_req_o   (mod_req_o),
  .mod_addr_o  (mod_addr_o),
  .mod_valid_i (mod_valid_i),
  .ram_we_o    (ram_we_o),
  .ram_idx_o   (ram_idx_o),
  .ram_wdata_o (ram_wdata_o),
  .cpu_valid_o (cpu_valid_o),
  .cpu_data_o  (cpu_data_o),
  .done_o      (done_o)
);

// File: tb/cwf_fill_seq_bench.sv
`timescale 1ns/1ps
module cwf_fill_seq_bench;
  localparam int N_MOD  = 4;
  localparam int WORD_W = 128;
  localparam int BLK_W  = 20;
  localparam int IDX_W  = 2;

  logic                    clk = 1'b0;
  logic                    rst_ni = 1'b0;
  logic                    req_valid = 1'b0;
  logic [BLK_W-1:0]        req_blk = '0;
  logic [IDX_W-1:0]        req_word = '0;
  logic [N_MOD-1:0]        mod_valid;
  logic [N_MOD*WORD_W-1:0] mod_rdata;
  logic                    req_ready_o, busy_o, ram_we_o, cpu_valid_o, done_o;
  logic [N_MOD-1:0]        mod_req_o;
  logic [BLK_W-1:0]        mod_addr_o, ram_blk_o, done_blk_o;
  logic [IDX_W-1:0]        ram_idx_o;
  logic [WORD_W-1:0]       ram_wdata_o, cpu_data_o;

  int checks = 0;
  int fails  = 0;
  int max_wait = 0;
  int wcnt = 0;

  always #2 clk = ~clk;

  cwf_fill_seq #(.N_MOD(N_MOD), .WORD_W(WORD_W), .BLK_W(BLK_W)) u_cwf_fill_seq (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_ready_o(req_ready_o),
    .req_blk_i(req_blk), .req_word_i(req_word), .busy_o(busy_o),
    .mod_req_o(mod_req_o), .mod_addr_o(mod_addr_o),
    .mod_valid_i(mod_valid), .mod_rdata_i(mod_rdata),
    .ram_we_o(ram_we_o), .ram_blk_o(ram_blk_o), .ram_idx_o(ram_idx_o),
    .ram_wdata_o(ram_wdata_o), .cpu_valid_o(cpu_valid_o), .cpu_data_o(cpu_data_o),
    .done_o(done_o), .done_blk_o(done_blk_o)
  );

  function automatic logic [WORD_W-1:0] mem_word(logic [BLK_W-1:0] b, int i);
    return {2'b11, b, 10'(i), 32'(b * 7 + i), 32'(b ^ 32'h5A5A), 32'(i * 13 + 1)};
  endfunction

  function automatic logic [IDX_W-1:0] exp_idx(logic [IDX_W-1:0] w, int n);
    return IDX_W'((int'(w) + n) % N_MOD);
  endfunction

  task automatic chk(bit ok, string req, logic [WORD_W-1:0] act, logic [WORD_W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model: answers the requested module after random wait cycles
  initial begin
    mod_valid = '0;
    mod_rdata = '0;
    forever begin
      @(posedge clk);
      #1;
      if (mod_valid != '0) begin
        mod_valid = '0;
      end else if (mod_req_o != '0) begin
        if (wcnt == 0) begin
          for (int k = 0; k < N_MOD; k++) begin
            if (mod_req_o[k]) begin
              mod_valid[k] = 1'b1;
              mod_rdata[k*WORD_W +: WORD_W] = mem_word(mod_addr_o, k);
            end
          end
          wcnt = (max_wait == 0) ? 0 : int'($urandom_range(max_wait, 0));
        end else begin
          wcnt--;
        end
      end
    end
  end

  task automatic run_fill(logic [BLK_W-1:0] blk, logic [IDX_W-1:0] w, bit spur);
    int n = 0;
    int fwd = 0;
    bit prev_we = 0;
    bit spur_on = 0;
    bit spur_done = 0;
    logic [N_MOD-1:0] prev_req = '0;
    logic [N_MOD-1:0] prev_vld = '0;
    logic [N_MOD-1:0] seen = '0;
    bit finished = 0;
    @(negedge clk);
    while (!req_ready_o) @(negedge clk);
    req_valid = 1'b1;
    req_blk   = blk;
    req_word  = w;
    @(negedge clk);
    req_valid = 1'b0;
    req_blk   = ~blk;
    chk(busy_o && !req_ready_o, "R8 busy after accept", {busy_o, req_ready_o}, 2'b10);
    for (int t = 0; t < 400 && !finished; t++) begin
      if (mod_req_o != '0)
        chk(mod_addr_o == blk, "R6 module address", mod_addr_o, blk);
      chk($countones(mod_req_o) <= 1, "R2 one module at a time", mod_req_o, 0);
      if (prev_req != '0 && (prev_req & prev_vld) == '0)
        chk(mod_req_o == prev_req, "R9 request held", mod_req_o, prev_req);
      if ((mod_req_o & mod_valid) != '0) begin
        chk((seen & mod_req_o) == '0, "R2 module accessed once", seen, 0);
        seen |= mod_req_o;
      end
      if (ram_we_o) begin
        chk(ram_idx_o == exp_idx(w, n), n == 0 ? "R3 first index" : "R4 wrap order",
            ram_idx_o, exp_idx(w, n));
        chk(ram_wdata_o == mem_word(blk, int'(exp_idx(w, n))), "R6 write data",
            ram_wdata_o, mem_word(blk, int'(exp_idx(w, n))));
        chk(ram_blk_o == blk, "R6 write block", ram_blk_o, blk);
        chk(cpu_valid_o == (n == 0), "R5 forward cycle", cpu_valid_o, n == 0);
        if (cpu_valid_o) begin
          fwd++;
          chk(cpu_data_o == ram_wdata_o, "R5 forward data", cpu_data_o, ram_wdata_o);
        end
        n++;
      end else begin
        chk(!cpu_valid_o, "R5 no forward without write", cpu_valid_o, 0);
      end
      if (spur_on) begin
        req_valid = 1'b0;
        spur_on = 0;
      end else if (spur && !spur_done && n == 1) begin
        req_valid = 1'b1;
        req_blk   = blk ^ 20'h0F0F3;
        req_word  = w + 2'd1;
        spur_on   = 1;
        spur_done = 1;
        chk(!req_ready_o, "R8 not ready while filling", req_ready_o, 0);
      end
      if (done_o) begin
        chk(n == N_MOD && prev_we && !ram_we_o, "R7 done after last write", n, N_MOD);
        chk(done_blk_o == blk, "R7 done block", done_blk_o, blk);
        chk(seen == '1 && fwd == 1, "R2 all modules, R5 single forward", seen, '1);
        finished = 1;
      end else begin
        prev_we  = ram_we_o;
        prev_req = mod_req_o;
        prev_vld = mod_valid;
        @(negedge clk);
      end
    end
    chk(finished, "R7 fill completes", finished, 1);
    req_valid = 1'b0;
    @(negedge clk);
    chk(!done_o && !busy_o && req_ready_o, "R7 pulse ends, R8 stray request ignored",
        {done_o, busy_o, req_ready_o}, 3'b001);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7021));
    repeat (3) @(negedge clk);
    chk(!busy_o && req_ready_o && mod_req_o == '0 && !ram_we_o && !cpu_valid_o && !done_o,
        "R1 reset state", {busy_o, req_ready_o, mod_req_o, ram_we_o, cpu_valid_o, done_o},
        9'b010000000);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!busy_o && req_ready_o && mod_req_o == '0, "R1 idle after reset",
        {busy_o, req_ready_o, mod_req_o}, 6'b010000);
    // directed: every start word, no waits
    for (int w = 0; w < N_MOD; w++) run_fill(20'h1000 + BLK_W'(w), IDX_W'(w), 0);
    // directed: last word first with long waits and a stray request
    max_wait = 6;
    run_fill(20'hFFFFF, 2'd3, 1);
    run_fill(20'h00000, 2'd0, 1);
    // random mix
    for (int i = 0; i < 40; i++) begin
      max_wait = int'($urandom_range(4, 0));
      run_fill(BLK_W'($urandom), IDX_W'($urandom_range(N_MOD - 1, 0)), bit'($urandom_range(1, 0)));
    end
    repeat (2) @(negedge clk);
    chk(!busy_o && mod_req_o == '0, "R1 idle at end", {busy_o, mod_req_o}, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule